// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block sits on the device side of a parallel flash interface. It watches the bus strobes and turns qualifying write cycles into commands for the program engine behind it. It starts in read-array mode. Reads need no command in that mode, and the block stays there until a recognised command sequence moves it out. A correctly unlocked sequence produces one of two results: a single-cycle program request carrying an address and a data word, or a stream of write-buffer load strobes closed by a commit or an abort.

A bypass mode shortens a word program from four bus writes to two. An accelerate input forces bypass mode and lifts sector-group protection for as long as it is held. A protection vector, one bit per sector group, blocks program commands to protected groups. Erase, cell programming and status polling are handled elsewhere.

Top module: `flash_cmd_decoder`

## Requirements
- R1: After reset, read_array is 1, bypass is 0 and no strobe output is active.
- R2: A bus write is counted only while ce_n=0, we_n=0 and oe_n=1. It is counted once, however many clocks it is held. A cycle with oe_n=0 has no effect on the sequence.
- R3: The writes (0x555, 0xAA), (0x2AA, 0x55), (0x555, 0xA0), then (A, D) give pgm_req with pgm_addr=A and pgm_data=D in the cycle after the fourth write is seen. Unlock addresses are compared on address bits [10:0]. Command codes are compared on data bits [7:0].
- R4: A write that breaks the expected sequence returns the block to read-array mode. No program is issued.
- R5: The two unlock writes, then (0x555, 0x20), set bypass=1 and read_array=0. In bypass mode, a write of 0xA0 at any address followed by (A, D) issues pgm_req for A and D.
- R6: In bypass mode, writes that are not commands are ignored and bypass stays set. A write of 0x90 followed by 0x00 leaves bypass mode. A write of 0x90 followed by any other value stays in bypass mode.
- R7: The sector group of an address is addr[ADDR_W-1 -: GRP_W]. A program to a group whose prot_map bit is 1 is dropped without pgm_req, and the block returns to read-array mode.
- R8: While accel=1, bypass reads 1 and protected groups accept programs. After accel returns to 0, bypass is 0 and protection applies again.
- R9: The two unlock writes, then 0x25, then a count C (C+1 words, C at most 15), then C+1 data writes give one buf_wr per data write with buf_idx counting 0..C. A final 0x29 write gives buf_commit.
- R10: A count value above 15 (more than 16 words) gives buf_abort and returns to read-array mode. No loads are taken.
- R11: A confirm write other than 0x29 gives buf_abort and no buf_commit.
- R12: pgm_req lasts exactly one clock cycle, and at most one of pgm_req, buf_wr, buf_commit and buf_abort is active in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| addr | input | ADDR_W | Word address |
| wdata | input | DATA_W | Write data |
| accel | input | 1 | Accelerate: forces bypass mode and lifts protection |
| prot_map | input | GROUPS | One protect bit per sector group |
| pgm_req | output | 1 | Single-cycle program request |
| pgm_addr | output | ADDR_W | Program address |
| pgm_data | output | DATA_W | Program data |
| buf_wr | output | 1 | Write-buffer load strobe |
| buf_idx | output | IDX_W | Slot index of the load |
| buf_addr | output | ADDR_W | Load address |
| buf_data | output | DATA_W | Load data |
| buf_commit | output | 1 | Buffer confirmed |
| buf_abort | output | 1 | Buffer operation abandoned |
| read_array | output | 1 | Block is in read-array mode |
| bypass | output | 1 | Bypass mode is in effect |

## Verification
A sequencer left in the wrong state shows up on the write after it. A lost unlock step suppresses the expected pgm_req. A stale state makes a later data write become a program, so an unexpected strobe appears one clock after that write. Bypass or read_array reads wrong straight after the command that should have changed it. A miscounted buffer index shows up on the first buf_idx of the load, or as a commit arriving one write early or late.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;
  localparam logic [10:0] UNLK_ADR_A = 11'h555;
  localparam logic [10:0] UNLK_ADR_B = 11'h2AA;
  localparam logic [7:0]  CODE_UNLK_A = 8'hAA;
  localparam logic [7:0]  CODE_UNLK_B = 8'h55;
  localparam logic [7:0]  CODE_PGM    = 8'hA0;
  localparam logic [7:0]  CODE_BYP_IN = 8'h20;
  localparam logic [7:0]  CODE_BYP_X  = 8'h90;
  localparam logic [7:0]  CODE_BYP_X2 = 8'h00;
  localparam logic [7:0]  CODE_BUF    = 8'h25;
  localparam logic [7:0]  CODE_CONF   = 8'h29;

  typedef enum logic [2:0] {
    ST_IDLE, ST_UNL1, ST_UNL2, ST_PGM, ST_BCNT, ST_BLOAD, ST_BCONF, ST_XEXIT
  } seq_st_t;

  function automatic logic adr_is(input logic [10:0] lo, input logic [10:0] ref_a);
    return lo == ref_a;
  endfunction
endpackage

// File: rtl/fcd_wr_detect.sv
module fcd_wr_detect (
  input  logic clk,
  input  logic rst_n,
  input  logic ce_n,
  input  logic oe_n,
  input  logic we_n,
  output logic wr_evt
);
  logic cond, cond_q;
  assign cond = !ce_n && !we_n && oe_n;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) cond_q <= 1'b0;
    else        cond_q <= cond;

  assign wr_evt = cond && !cond_q;

  // R2
  wr_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_evt |=> !wr_evt);
endmodule

// File: rtl/fcd_prot_gate.sv
module fcd_prot_gate #(
  parameter int GROUPS = 8,
  localparam int GRP_W = $clog2(GROUPS)
) (
  input  logic [GRP_W-1:0]  grp,
  input  logic [GROUPS-1:0] prot_map,
  input  logic              accel,
  output logic              blocked
);
  assign blocked = prot_map[grp] && !accel;
endmodule

// File: rtl/fcd_seq.sv
module fcd_seq
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int DATA_W    = 16,
  parameter int BUF_WORDS = 16,
  localparam int IDX_W    = $clog2(BUF_WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_evt,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] data,
  input  logic              accel,
  input  logic              blocked,
  output logic              pgm_req,
  output logic [ADDR_W-1:0] pgm_addr,
  output logic [DATA_W-1:0] pgm_data,
  output logic              buf_wr,
  output logic [IDX_W-1:0]  buf_idx,
  output logic [ADDR_W-1:0] buf_addr,
  output logic [DATA_W-1:0] buf_data,
  output logic              buf_commit,
  output logic              buf_abort,
  output logic              read_array,
  output logic              bypass
);
  seq_st_t st;
  logic byp_q, accel_q;
  logic [IDX_W-1:0] idx, cnt_last;
  logic [7:0]  cmd;
  logic [10:0] alo;
  logic accel_chg, eff_byp, cnt_over, in_buf;

  assign cmd       = data[7:0];
  assign alo       = addr[10:0];
  assign accel_chg = accel ^ accel_q;
  assign eff_byp   = byp_q || accel;
  assign cnt_over  = data > DATA_W'(BUF_WORDS - 1);
  assign in_buf    = (st == ST_BCNT) || (st == ST_BLOAD) || (st == ST_BCONF);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_IDLE; byp_q <= 1'b0; accel_q <= 1'b0;
      idx <= '0; cnt_last <= '0;
      pgm_req <= 1'b0; pgm_addr <= '0; pgm_data <= '0;
      buf_wr <= 1'b0; buf_idx <= '0; buf_addr <= '0; buf_data <= '0;
      buf_commit <= 1'b0; buf_abort <= 1'b0;
    end else begin
      accel_q <= accel;
      pgm_req <= 1'b0; buf_wr <= 1'b0; buf_commit <= 1'b0; buf_abort <= 1'b0;
      if (accel_chg) begin
        st <= ST_IDLE;
        if (!accel) byp_q <= 1'b0;
        if (in_buf) buf_abort <= 1'b1;
      end else if (wr_evt) begin
        unique case (st)
          ST_IDLE:
            if (eff_byp) begin
              if (cmd == CODE_PGM)                    st <= ST_PGM;
              else if (cmd == CODE_BUF && !blocked)   st <= ST_BCNT;
              else if (cmd == CODE_BYP_X)             st <= ST_XEXIT;
            end else if (adr_is(alo, UNLK_ADR_A) && cmd == CODE_UNLK_A) begin
              st <= ST_UNL1;
            end
          ST_UNL1:
            st <= (adr_is(alo, UNLK_ADR_B) && cmd == CODE_UNLK_B) ? ST_UNL2 : ST_IDLE;
          ST_UNL2: begin
            st <= ST_IDLE;
            if (adr_is(alo, UNLK_ADR_A) && cmd == CODE_PGM)         st <= ST_PGM;
            else if (adr_is(alo, UNLK_ADR_A) && cmd == CODE_BYP_IN) byp_q <= 1'b1;
            else if (cmd == CODE_BUF && !blocked)                   st <= ST_BCNT;
          end
          ST_PGM: begin
            st <= ST_IDLE;
            if (!blocked) begin
              pgm_req <= 1'b1; pgm_addr <= addr; pgm_data <= data;
            end
          end
          ST_BCNT:
            if (cnt_over) begin
              buf_abort <= 1'b1; st <= ST_IDLE;
            end else begin
              cnt_last <= data[IDX_W-1:0]; idx <= '0; st <= ST_BLOAD;
            end
          ST_BLOAD: begin
            buf_wr <= 1'b1; buf_idx <= idx; buf_addr <= addr; buf_data <= data;
            idx <= idx + 1'b1;
            if (idx == cnt_last) st <= ST_BCONF;
          end
          ST_BCONF: begin
            st <= ST_IDLE;
            if (cmd == CODE_CONF) buf_commit <= 1'b1;
            else                  buf_abort  <= 1'b1;
          end
          ST_XEXIT: begin
            st <= ST_IDLE;
            if (cmd == CODE_BYP_X2) byp_q <= 1'b0;
          end
          default: st <= ST_IDLE;
        endcase
      end
    end
  end

  assign read_array = (st == ST_IDLE) && !eff_byp;
  assign bypass     = eff_byp;

  // R12
  pgm_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pgm_req |=> !pgm_req);
  // R12
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({pgm_req, buf_wr, buf_commit, buf_abort}));
  // R3
  pgm_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pgm_req |-> $past(st) == ST_PGM);
  // R7
  pgm_prot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pgm_req |-> !$past(blocked));
  // R10 R11
  abort_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    buf_abort |-> st == ST_IDLE);
endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder #(
  parameter int ADDR_W    = 16,
  parameter int DATA_W    = 16,
  parameter int GROUPS    = 8,
  parameter int BUF_WORDS = 16,
  localparam int GRP_W    = $clog2(GROUPS),
  localparam int IDX_W    = $clog2(BUF_WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              we_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              accel,
  input  logic [GROUPS-1:0] prot_map,
  output logic              pgm_req,
  output logic [ADDR_W-1:0] pgm_addr,
  output logic [DATA_W-1:0] pgm_data,
  output logic              buf_wr,
  output logic [IDX_W-1:0]  buf_idx,
  output logic [ADDR_W-1:0] buf_addr,
  output logic [DATA_W-1:0] buf_data,
  output logic              buf_commit,
  output logic              buf_abort,
  output logic              read_array,
  output logic              bypass
);
  logic wr_evt, blocked;

  fcd_wr_detect u_wr (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n), .wr_evt(wr_evt)
  );

  fcd_prot_gate #(.GROUPS(GROUPS)) u_prot (
    .grp(addr[ADDR_W-1 -: GRP_W]), .prot_map(prot_map), .accel(accel), .blocked(blocked)
  );

  fcd_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .BUF_WORDS(BUF_WORDS)) u_seq (
    .clk(clk), .rst_n(rst_n), .wr_evt(wr_evt), .addr(addr), .data(wdata),
    .accel(accel), .blocked(blocked),
    .pgm_req(pgm_req), .pgm_addr(pgm_addr), .pgm_data(pgm_data),
    .buf_wr(buf_wr), .buf_idx(buf_idx), .buf_addr(buf_addr), .buf_data(buf_data),
    .buf_commit(buf_commit), .buf_abort(buf_abort),
    .read_array(read_array), .bypass(bypass)
  );
endmodule

// File: tb/tb_flash_cmd_decoder.sv
module tb_flash_cmd_decoder;
  logic clk = 1'b0, rst_n = 1'b0;
  logic ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1, accel = 1'b0;
  logic [15:0] addr = '0, wdata = '0;
  logic [7:0]  prot_map = '0;
  logic pgm_req, buf_wr, buf_commit, buf_abort, read_array, bypass;
  logic [15:0] pgm_addr, pgm_data, buf_addr, buf_data;
  logic [3:0]  buf_idx;

  int n_chk = 0, n_fail = 0;
  int n_pgm, n_bwr, n_commit, n_abort;
  logic [15:0] s_paddr, s_pdata, s_baddr, s_bdata;
  logic [3:0]  s_bidx;

  always #2 clk = ~clk;

  flash_cmd_decoder dut (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
    .addr(addr), .wdata(wdata), .accel(accel), .prot_map(prot_map),
    .pgm_req(pgm_req), .pgm_addr(pgm_addr), .pgm_data(pgm_data),
    .buf_wr(buf_wr), .buf_idx(buf_idx), .buf_addr(buf_addr), .buf_data(buf_data),
    .buf_commit(buf_commit), .buf_abort(buf_abort),
    .read_array(read_array), .bypass(bypass)
  );

  task automatic chk(input logic ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic sample();
    if (pgm_req) begin n_pgm++; s_paddr = pgm_addr; s_pdata = pgm_data; end
    if (buf_wr) begin n_bwr++; s_bidx = buf_idx; s_baddr = buf_addr; s_bdata = buf_data; end
    if (buf_commit) n_commit++;
    if (buf_abort)  n_abort++;
  endtask

  task automatic clr();
    n_pgm = 0; n_bwr = 0; n_commit = 0; n_abort = 0;
  endtask

  // one bus write; strobes are collected while held and one cycle after release
  task automatic bus_wr(input logic [15:0] a, input logic [15:0] d,
                        input int hold = 1, input logic oe = 1'b1);
    @(negedge clk); addr = a; wdata = d; ce_n = 1'b0; we_n = 1'b0; oe_n = oe;
    for (int i = 0; i < hold; i++) begin @(negedge clk); sample(); end
    ce_n = 1'b1; we_n = 1'b1; oe_n = 1'b1;
    @(negedge clk); sample();
  endtask

  task automatic unlock();
    bus_wr(16'h0555, 16'h00AA);
    bus_wr(16'h02AA, 16'h0055);
  endtask

  task automatic t_reset();
    chk(read_array == 1'b1, "R1", "read_array", read_array, 1);
    chk(bypass == 1'b0, "R1", "bypass", bypass, 0);
    chk({pgm_req, buf_wr, buf_commit, buf_abort} == 4'b0, "R1", "strobes",
        {pgm_req, buf_wr, buf_commit, buf_abort}, 0);
  endtask

  task automatic t_std_program();
    clr(); unlock(); bus_wr(16'h0555, 16'h00A0);
    chk(n_pgm == 0, "R3", "early pgm", n_pgm, 0);
    bus_wr(16'h1234, 16'hBEEF);
    chk(n_pgm == 1, "R12", "pgm pulse count", n_pgm, 1);
    chk(s_paddr == 16'h1234, "R3", "pgm_addr", s_paddr, 16'h1234);
    chk(s_pdata == 16'hBEEF, "R3", "pgm_data", s_pdata, 16'hBEEF);
    chk(read_array == 1'b1, "R3", "read_array after", read_array, 1);
  endtask

  task automatic t_mismatch();
    clr();
    bus_wr(16'h0555, 16'h00AA);
    bus_wr(16'h0123, 16'h0055);
    chk(read_array == 1'b1, "R4", "read_array", read_array, 1);
    bus_wr(16'h0555, 16'h00A0);
    bus_wr(16'h1000, 16'h1111);
    chk(n_pgm == 0, "R4", "pgm after bad unlock", n_pgm, 0);
  endtask

  task automatic t_write_qual();
    clr();
    bus_wr(16'h0555, 16'h00AA);
    bus_wr(16'h02AA, 16'h0055, 1, 1'b0);
    bus_wr(16'h02AA, 16'h0055);
    bus_wr(16'h0555, 16'h00A0);
    bus_wr(16'h0040, 16'h00C3, 4);
    chk(n_pgm == 1, "R2", "pgm count long write", n_pgm, 1);
    chk(s_pdata == 16'h00C3, "R2", "pgm_data", s_pdata, 16'h00C3);
    chk(read_array == 1'b1, "R2", "read_array", read_array, 1);
  endtask

  task automatic t_bypass();
    clr(); unlock(); bus_wr(16'h0555, 16'h0020);
    chk(bypass == 1'b1, "R5", "bypass", bypass, 1);
    chk(read_array == 1'b0, "R5", "read_array", read_array, 0);
    bus_wr(16'h0777, 16'h00A0);
    bus_wr(16'h0200, 16'h5A5A);
    chk(n_pgm == 1 && s_paddr == 16'h0200 && s_pdata == 16'h5A5A, "R5", "bypass pgm",
        s_pdata, 16'h5A5A);
  endtask

  task automatic t_bypass_exit();
    clr();
    bus_wr(16'h0555, 16'h00AA);
    chk(bypass == 1'b1, "R6", "bypass after junk", bypass, 1);
    bus_wr(16'h0000, 16'h00A0);
    bus_wr(16'h0300, 16'h0001);
    chk(n_pgm == 1, "R6", "pgm after junk", n_pgm, 1);
    bus_wr(16'h0000, 16'h0090);
    bus_wr(16'h0000, 16'h0012);
    chk(bypass == 1'b1, "R6", "bypass after 90/12", bypass, 1);
    bus_wr(16'h0000, 16'h0090);
    bus_wr(16'h0000, 16'h0000);
    chk(bypass == 1'b0, "R6", "bypass after 90/00", bypass, 0);
    chk(read_array == 1'b1, "R6", "read_array", read_array, 1);
  endtask

  task automatic t_protect();
    prot_map = 8'h04;
    clr(); unlock(); bus_wr(16'h0555, 16'h00A0); bus_wr(16'h4010, 16'h7E7E);
    chk(n_pgm == 0, "R7", "protected pgm", n_pgm, 0);
    chk(read_array == 1'b1, "R7", "read_array", read_array, 1);
    clr(); unlock(); bus_wr(16'h0555, 16'h00A0); bus_wr(16'h6000, 16'h0101);
    chk(n_pgm == 1, "R7", "open group pgm", n_pgm, 1);
  endtask

  task automatic t_accel();
    @(negedge clk); accel = 1'b1;
    repeat (2) @(negedge clk);
    chk(bypass == 1'b1, "R8", "bypass under accel", bypass, 1);
    clr(); bus_wr(16'h0000, 16'h00A0); bus_wr(16'h4010, 16'h9999);
    chk(n_pgm == 1 && s_paddr == 16'h4010, "R8", "protected pgm under accel", n_pgm, 1);
    @(negedge clk); accel = 1'b0;
    repeat (2) @(negedge clk);
    chk(bypass == 1'b0, "R8", "bypass after release", bypass, 0);
    chk(read_array == 1'b1, "R8", "read_array after release", read_array, 1);
    clr(); unlock(); bus_wr(16'h0555, 16'h00A0); bus_wr(16'h4010, 16'h9999);
    chk(n_pgm == 0, "R8", "protection restored", n_pgm, 0);
    prot_map = 8'h00;
  endtask

  task automatic t_buffer(input int words);
    int bad = 0;
    clr(); unlock();
    bus_wr(16'h2000, 16'h0025);
    bus_wr(16'h2000, 16'(words - 1));
    for (int i = 0; i < words; i++) begin
      n_bwr = 0;
      bus_wr(16'h2000 + 16'(i), 16'hA000 + 16'(i));
      if (n_bwr != 1 || s_bidx != 4'(i) || s_baddr != 16'h2000 + 16'(i) ||
          s_bdata != 16'hA000 + 16'(i)) bad++;
    end
    chk(bad == 0, "R9", "load strobes", bad, 0);
    chk(n_commit == 0, "R9", "early commit", n_commit, 0);
    bus_wr(16'h2000, 16'h0029);
    chk(n_commit == 1 && n_abort == 0, "R9", "commit", n_commit, 1);
    chk(read_array == 1'b1, "R9", "read_array", read_array, 1);
  endtask

  task automatic t_buf_over();
    clr(); unlock();
    bus_wr(16'h2000, 16'h0025);
    bus_wr(16'h2000, 16'h0010);
    chk(n_abort == 1, "R10", "abort on count 16", n_abort, 1);
    chk(read_array == 1'b1, "R10", "read_array", read_array, 1);
    bus_wr(16'h2000, 16'h0001);
    chk(n_bwr == 0, "R10", "no loads", n_bwr, 0);
  endtask

  task automatic t_buf_badconf();
    clr(); unlock();
    bus_wr(16'h2000, 16'h0025);
    bus_wr(16'h2000, 16'h0000);
    bus_wr(16'h2005, 16'h1234);
    bus_wr(16'h2000, 16'h0030);
    chk(n_abort == 1 && n_commit == 0, "R11", "bad confirm", n_abort, 1);
    chk(read_array == 1'b1, "R11", "read_array", read_array, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_std_program();
    t_mismatch();
    t_write_qual();
    t_bypass();
    t_bypass_exit();
    t_protect();
    t_accel();
    t_buffer(4);
    t_buffer(16);
    t_buf_over();
    t_buf_badconf();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule